// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block sits in the front end of a superscalar core. Each cycle it decides whether a candidate instruction may join the dispatch group now being built, or whether it has to wait. A group has five slots. The last slot is kept for a branch. Some instruction classes are limited to the early slots, and one pairing inside a group must be broken up by a no-op. The decoder supplies a class descriptor for the candidate: unit type, first-only flag, whole-group flag, two-slot (cracked) flag, and markers for a count-register write and a branch through the count register. The block answers combinationally with a two-bit hazard code.

The scheduler pulses `issue` when it emits the candidate. It pulses `advance` for a cycle in which nothing is emitted. The block counts used slots and remembers whether the group already holds a count-register write. It closes the group once five slots are consumed. Address comparison between loads and stores, instruction decode and the injection of the no-op itself belong to other blocks.

Top module: `dgsc_slot_checker`

## Requirements
- R1: After a synchronous active-low reset, `slots_used` is 0, `ctr_pending` is 0 and `adv_error` is 0.
- R2: Unit codes are 0 pseudo, 1 fixed-point, 2 load/store, 3 floating-point, 4 vector arithmetic, 5 vector permute, 6 condition-register, 7 branch. Any code from 1 to 5 gives hazard 2'b01 (stall) when four slots are used. A branch with no other restriction gives 2'b00 there.
- R3: A candidate with the first-only or the whole-group flag gives a stall whenever `slots_used` is not 0.
- R4: A cracked candidate gives a stall when more than two slots are used. When issued it consumes two slots.
- R5: A condition-register candidate (code 6) gives a stall when two or more slots are used.
- R6: Issuing a branch or a whole-group instruction closes the group. `slots_used` is 0 in the next cycle.
- R7: An `advance` with no `issue` consumes one slot. When the count reaches five, the group closes: the count returns to 0 and `ctr_pending` clears.
- R8: Issuing a candidate marked as a count-register write sets `ctr_pending`. While it is set, a candidate marked as a branch through the count register gives hazard 2'b10 (insert no-op). This no longer happens once the group has closed.
- R9: A pseudo candidate (code 0) always gives hazard 2'b00, and issuing it leaves `slots_used` unchanged.
- R10: If a stall and an insert-no-op condition hold together, the hazard is 2'b01. The code 2'b11 never appears.
- R11: Asserting `advance` in the same cycle as `issue` is illegal. It sets `adv_error`, which stays set until reset. The advance is ignored and only the issue is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cand_unit | input | 3 | Unit class code of the candidate |
| cand_first | input | 1 | Candidate may only start a group |
| cand_single | input | 1 | Candidate occupies a whole group |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_ctr_write | input | 1 | Candidate writes the count register |
| cand_ctr_branch | input | 1 | Candidate branches through the count register |
| issue | input | 1 | Candidate is emitted this cycle |
| advance | input | 1 | Empty cycle, one slot is consumed |
| hazard | output | 2 | 00 none, 01 stall, 10 insert no-op |
| slots_used | output | 3 | Slots consumed in the current group |
| ctr_pending | output | 1 | Group already holds a count-register write |
| adv_error | output | 1 | Sticky flag for an advance that coincided with an issue |

## Verification
The assertions assume the scheduler pulses `issue` only when the hazard reads none, so the count never rises past the legal window. They also assume the decoder never marks a branch as cracked. The stimulus table keeps both rules and steps through every restricted slot position. Only the directed error test drives `issue` and `advance` together. The assertions that track single-cycle slot steps are gated off in that cycle.

// File: rtl/dgsc_pkg.sv
// Package: shared encodings of the dispatch group slot checker.
// Assumes: unit codes and hazard codes are fixed by the decoder contract.
package dgsc_pkg;

    typedef enum logic [2:0] {
        UNIT_PSEUDO = 3'd0,
        UNIT_FIX    = 3'd1,
        UNIT_MEM    = 3'd2,
        UNIT_FLT    = 3'd3,
        UNIT_VEC    = 3'd4,
        UNIT_PERM   = 3'd5,
        UNIT_CREG   = 3'd6,
        UNIT_BR     = 3'd7
    } unit_t;

    typedef enum logic [1:0] {
        HZ_NONE  = 2'b00,
        HZ_STALL = 2'b01,
        HZ_NOOP  = 2'b10
    } hazard_t;

endpackage

// File: rtl/dgsc_rules.sv
// Module: combinational slot-legality rules for one candidate.
// Assumes: slots is below GROUP_SLOTS (the tracker closes full groups).
module dgsc_rules
    import dgsc_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    parameter int CRACK_MAX   = 2,
    parameter int CNT_W       = 3
) (
    input  unit_t            unit,
    input  logic             first_only,
    input  logic             single,
    input  logic             cracked,
    input  logic             ctr_branch,
    input  logic [CNT_W-1:0] slots,
    input  logic             ctr_set,
    output hazard_t          hazard
);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(GROUP_SLOTS - 1);
    localparam logic [CNT_W-1:0] CR_LIM    = CNT_W'(CR_SLOTS);
    localparam logic [CNT_W-1:0] CRACK_LIM = CNT_W'(CRACK_MAX);

    logic stall_pos;
    logic stall_unit;
    logic noop_pair;

    // Position rules from flags: first-only/whole-group and cracked limits.
    always_comb begin
        stall_pos = ((first_only || single) && (slots != '0)) ||
                    (cracked && (slots > CRACK_LIM));
    end

    // Unit-class rules: non-branch cannot take the last slot, CR early only.
    always_comb begin
        unique case (unit)
            UNIT_FIX, UNIT_MEM, UNIT_FLT, UNIT_VEC, UNIT_PERM:
                stall_unit = (slots == LAST_IDX);
            UNIT_CREG:
                stall_unit = (slots >= CR_LIM);
            default:
                stall_unit = 1'b0;
        endcase
    end

    // Count-register write followed by branch through it in one group.
    always_comb begin
        noop_pair = ctr_set && ctr_branch;
    end

    // Final priority: pseudo never, then stall, then insert no-op.
    always_comb begin
        if (unit == UNIT_PSEUDO)
            hazard = HZ_NONE;
        else if (stall_pos || stall_unit)
            hazard = HZ_STALL;
        else if (noop_pair)
            hazard = HZ_NOOP;
        else
            hazard = HZ_NONE;
    end

endmodule

// File: rtl/dgsc_slot_track.sv
// Module: slot counter and group state of the current dispatch group.
// Assumes: issue is pulsed only for legal candidates; branches are not cracked.
module dgsc_slot_track
    import dgsc_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  unit_t            unit,
    input  logic             single,
    input  logic             cracked,
    input  logic             ctr_write,
    input  logic             issue,
    input  logic             advance,
    output logic [CNT_W-1:0] slots,
    output logic             ctr_set,
    output logic             adv_err
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_SLOTS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(GROUP_SLOTS);

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt_slots;
    logic             nxt_ctr;
    logic             real_issue;

    // Real issue excludes pseudo instructions, which use no slot.
    always_comb begin
        real_issue = issue && (unit != UNIT_PSEUDO);
    end

    // Next slot count and count-register state, with group close.
    always_comb begin
        base      = ((unit == UNIT_BR) || single) ? LAST_IDX : slots;
        nxt_slots = slots;
        nxt_ctr   = ctr_set;
        if (real_issue) begin
            nxt_slots = base + CNT_W'(1) + {{(CNT_W-1){1'b0}}, cracked};
            nxt_ctr   = ctr_set || ctr_write;
        end else if (advance && !issue) begin
            nxt_slots = slots + CNT_W'(1);
        end
        if (nxt_slots >= FULL) begin
            nxt_slots = '0;
            nxt_ctr   = 1'b0;
        end
    end

    // Group state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots   <= '0;
            ctr_set <= 1'b0;
        end else begin
            slots   <= nxt_slots;
            ctr_set <= nxt_ctr;
        end
    end

    // Sticky flag for an advance overlapping an issue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            adv_err <= 1'b0;
        else if (issue && advance)
            adv_err <= 1'b1;
    end

endmodule

// File: rtl/dgsc_slot_checker.sv
// Module: top of the dispatch group slot checker.
// Assumes: candidate descriptor is stable while hazard is being evaluated.
module dgsc_slot_checker
    import dgsc_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    parameter int CRACK_MAX   = 2,
    localparam int CNT_W      = $clog2(GROUP_SLOTS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cand_unit,
    input  logic             cand_first,
    input  logic             cand_single,
    input  logic             cand_cracked,
    input  logic             cand_ctr_write,
    input  logic             cand_ctr_branch,
    input  logic             issue,
    input  logic             advance,
    output logic [1:0]       hazard,
    output logic [CNT_W-1:0] slots_used,
    output logic             ctr_pending,
    output logic             adv_error
);
    unit_t   unit;
    hazard_t haz;

    // Map the raw unit code onto the shared type.
    always_comb begin
        unit   = unit_t'(cand_unit);
        hazard = haz;
    end

    dgsc_rules #(
        .GROUP_SLOTS(GROUP_SLOTS),
        .CR_SLOTS   (CR_SLOTS),
        .CRACK_MAX  (CRACK_MAX),
        .CNT_W      (CNT_W)
    ) u_rules (
        .unit       (unit),
        .first_only (cand_first),
        .single     (cand_single),
        .cracked    (cand_cracked),
        .ctr_branch (cand_ctr_branch),
        .slots      (slots_used),
        .ctr_set    (ctr_pending),
        .hazard     (haz)
    );

    dgsc_slot_track #(
        .GROUP_SLOTS(GROUP_SLOTS),
        .CNT_W      (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit       (unit),
        .single     (cand_single),
        .cracked    (cand_cracked),
        .ctr_write  (cand_ctr_write),
        .issue      (issue),
        .advance    (advance),
        .slots      (slots_used),
        .ctr_set    (ctr_pending),
        .adv_err    (adv_error)
    );

endmodule

// File: rtl/dgsc_slot_checker_sva.sv
// Module: property checker bound to the dispatch group slot checker.
// Assumes: issue is pulsed only when hazard is none.
module dgsc_slot_checker_sva #(
    parameter int GROUP_SLOTS = 5,
    parameter int CNT_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cand_unit,
    input logic             cand_single,
    input logic             issue,
    input logic             advance,
    input logic [1:0]       hazard,
    input logic [CNT_W-1:0] slots_used,
    input logic             adv_error
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_SLOTS - 1);

    AST_SLOTS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slots_used <= LAST_IDX);                                            // R7
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !issue && slots_used < LAST_IDX)
        |=> slots_used == $past(slots_used) + CNT_W'(1));                   // R7
    AST_ADV_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !issue && slots_used == LAST_IDX) |=> slots_used == '0); // R7
    AST_NB_LAST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit >= 3'd1 && cand_unit <= 3'd5 && slots_used == LAST_IDX)
        |-> hazard == 2'b01);                                               // R2
    AST_CR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit == 3'd6 && slots_used >= CNT_W'(2)) |-> hazard == 2'b01); // R5
    AST_PSEUDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit == 3'd0) |-> hazard == 2'b00);                           // R9
    AST_PSEUDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !advance && cand_unit == 3'd0) |=> $stable(slots_used));  // R9
    AST_CLOSE_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !advance && (cand_unit == 3'd7 || cand_single))
        |=> slots_used == '0);                                              // R6
    AST_HAZ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        hazard != 2'b11);                                                   // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        adv_error |=> adv_error);                                           // R11
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && advance) |=> adv_error);                                  // R11

endmodule

bind dgsc_slot_checker dgsc_slot_checker_sva #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .CNT_W      (CNT_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_unit   (cand_unit),
    .cand_single (cand_single),
    .issue       (issue),
    .advance     (advance),
    .hazard      (hazard),
    .slots_used  (slots_used),
    .adv_error   (adv_error)
);

// File: tb/dgsc_slot_checker_test.sv
// Bench: vector table walk plus directed reset and error tests.
module dgsc_slot_checker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cand_unit = '0;
    logic       cand_first = 0, cand_single = 0, cand_cracked = 0;
    logic       cand_ctr_write = 0, cand_ctr_branch = 0;
    logic       issue = 0, advance = 0;
    logic [1:0] hazard;
    logic [2:0] slots_used;
    logic       ctr_pending, adv_error;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    dgsc_slot_checker uut (
        .clk(clk), .rst_n(rst_n), .cand_unit(cand_unit),
        .cand_first(cand_first), .cand_single(cand_single),
        .cand_cracked(cand_cracked), .cand_ctr_write(cand_ctr_write),
        .cand_ctr_branch(cand_ctr_branch), .issue(issue), .advance(advance),
        .hazard(hazard), .slots_used(slots_used),
        .ctr_pending(ctr_pending), .adv_error(adv_error)
    );

    // Vector: unit, first, single, cracked, ctrw, ctrb, issue, adv, exp hazard, exp slots after, req
    function automatic logic [18:0] mk(int u, int f, int s, int c, int w, int b,
                                       int i, int a, int h, int sl, int r);
        return {u[2:0], f[0], s[0], c[0], w[0], b[0], i[0], a[0], h[1:0], sl[2:0], r[3:0]};
    endfunction

    localparam int NV = 25;
    localparam logic [18:0] VEC [NV] = '{
        mk(1,0,0,0,0,0,1,0, 0,1, 2),  // R2 fixed-point takes slot
        mk(0,0,0,0,0,0,1,0, 0,1, 9),  // R9 pseudo uses no slot
        mk(6,0,0,0,0,0,0,0, 0,1, 5),  // R5 CR allowed at 1
        mk(6,0,0,0,0,0,1,0, 0,2, 5),  // R5 CR issued
        mk(6,0,0,0,0,0,0,0, 1,2, 5),  // R5 CR stalls at 2
        mk(1,1,0,0,0,0,0,0, 1,2, 3),  // R3 first-only stalls
        mk(2,0,0,1,0,0,1,0, 0,4, 4),  // R4 cracked at 2 takes two
        mk(3,0,0,0,0,0,0,0, 1,4, 2),  // R2 float stalls at 4
        mk(2,0,0,1,0,0,0,0, 1,4, 4),  // R4 cracked stalls at 4
        mk(7,0,0,0,0,0,1,0, 0,0, 6),  // R6 branch at last slot closes
        mk(1,0,1,0,0,0,1,0, 0,0, 6),  // R6 whole-group closes
        mk(1,0,0,0,1,0,1,0, 0,1, 8),  // R8 count-register write
        mk(7,0,0,0,0,1,0,0, 2,1, 8),  // R8 insert no-op
        mk(7,1,0,0,0,1,0,0, 1,1,10),  // R10 stall over no-op
        mk(0,0,0,0,0,0,0,1, 0,2, 7),  // R7 advance
        mk(0,0,0,0,0,0,0,1, 0,3, 7),
        mk(0,0,0,0,0,0,0,1, 0,4, 7),
        mk(0,0,0,0,0,0,0,1, 0,0, 7),  // R7 close
        mk(7,0,0,0,0,1,0,0, 0,0, 8),  // R8 cleared by close
        mk(4,0,0,0,0,0,1,0, 0,1, 2),
        mk(5,0,0,0,0,0,1,0, 0,2, 2),
        mk(1,0,0,0,0,0,1,0, 0,3, 2),
        mk(4,0,0,1,0,0,0,0, 1,3, 4),  // R4 cracked stalls at 3
        mk(5,0,0,0,0,0,1,0, 0,4, 2),
        mk(1,0,0,1,0,0,1,0, 1,4, 4)   // R4 stall at 4, issue withheld below
    };

    task automatic check(input logic ok, input int req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cand_unit = 0; cand_first = 0; cand_single = 0; cand_cracked = 0;
        cand_ctr_write = 0; cand_ctr_branch = 0; issue = 0; advance = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL R0 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(slots_used == 0, 1, "slots after reset", slots_used, 0);
        check(ctr_pending == 0, 1, "ctr after reset", ctr_pending, 0);
        check(adv_error == 0, 1, "err after reset", adv_error, 0);

        for (int k = 0; k < NV; k++) begin
            logic [18:0] v;
            v = VEC[k];
            @(negedge clk);
            cand_unit = v[18:16]; cand_first = v[15]; cand_single = v[14];
            cand_cracked = v[13]; cand_ctr_write = v[12]; cand_ctr_branch = v[11];
            // Only issue when the expected hazard is none (legal use)
            issue = v[10] && (v[8:7] == 2'b00); advance = v[9];
            #1;
            check(hazard == v[8:7], int'(v[3:0]), $sformatf("hazard step %0d", k),
                  hazard, v[8:7]);
            @(posedge clk); #1;
            check(slots_used == v[6:4], int'(v[3:0]), $sformatf("slots step %0d", k),
                  slots_used, v[6:4]);
        end

        // R8 ctr_pending visible after a write, cleared after close
        @(negedge clk); idle_inputs(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        cand_unit = 1; cand_ctr_write = 1; issue = 1;
        @(posedge clk); #1;
        check(ctr_pending == 1, 8, "ctr set", ctr_pending, 1);
        @(negedge clk); idle_inputs(); advance = 1;
        repeat (4) @(posedge clk);
        #1;
        check(ctr_pending == 0 && slots_used == 0, 7, "ctr cleared on close",
              ctr_pending, 0);

        // R11 overlap of issue and advance: only the issue counts, flag sticks
        @(negedge clk); idle_inputs(); cand_unit = 1; issue = 1; advance = 1;
        @(posedge clk); #1;
        check(adv_error == 1, 11, "error set", adv_error, 1);
        check(slots_used == 1, 11, "advance ignored", slots_used, 1);
        @(negedge clk); idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        check(adv_error == 1, 11, "error sticky", adv_error, 1);

        // R1 reset mid-group clears everything
        @(negedge clk); cand_unit = 1; cand_ctr_write = 1; issue = 1;
        @(negedge clk); idle_inputs(); rst_n = 0;
        @(posedge clk); #1;
        check(slots_used == 0, 1, "slots after mid reset", slots_used, 0);
        check(ctr_pending == 0, 1, "ctr after mid reset", ctr_pending, 0);
        check(adv_error == 0, 1, "err after mid reset", adv_error, 0);
        @(negedge clk); rst_n = 1;

        // R3 whole-group candidate allowed at 0, stalls at 1
        cand_unit = 2; cand_single = 1; #1;
        check(hazard == 2'b00, 3, "single at 0", hazard, 0);
        @(negedge clk); idle_inputs(); advance = 1;
        @(negedge clk); idle_inputs(); cand_unit = 2; cand_single = 1; #1;
        check(hazard == 2'b01, 3, "single at 1", hazard, 1);

        // R2 branch with no flags allowed at slot 4
        @(negedge clk); idle_inputs(); advance = 1;
        repeat (3) @(negedge clk);
        idle_inputs(); cand_unit = 7; #1;
        check(slots_used == 4 && hazard == 2'b00, 2, "branch at last slot", hazard, 0);

        @(negedge clk); idle_inputs();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule